// File: doc/BRIEF.md
# Posted Write Buffer with Merging and Barriers

This block sits between a processor core and a slower bus port. It takes core writes at full rate while a slot is free, so the core does not wait for the bus. The writes then go to the bus one at a time, in the order they arrived. Each write carries a memory-type tag. Normal-memory writes go into the buffer and may combine into a slot that is still waiting. Device writes go into the buffer but never combine. Strongly ordered writes skip the buffer: they wait until the buffer is empty, then go straight to the bus.

Two barrier kinds let software order its accesses. The memory barrier blocks further writes and raises a memory-hold output, while other core work carries on. The synchronization barrier raises a full-core stall. Both finish with a one-cycle done pulse once every earlier write has been acknowledged on the bus. An idle output tells a standby-entry sequence when nothing is left in flight.

The core write port follows valid/ready rules. A write transfers in a cycle where `wr_valid` and `wr_ready` are both high. While `wr_valid` is high and `wr_ready` is low, the core must hold every `wr_*` field stable. The bus port follows the same rule: `bus_valid` is the valid and `bus_ack` is the ready. A bus write completes in the cycle where both are high. `bus_ack` has no effect while `bus_valid` is low.

Top module: `post_wbuf`

## Requirements
- R1: While a slot is free and no barrier is active, a normal (`wr_mtype`=0) or device (`wr_mtype`=1) write is accepted in the same cycle it is presented.
- R2: With all 4 slots occupied, a write that cannot merge sees `wr_ready` low. It is accepted only after the bus has acknowledged at least one buffered write.
- R3: A normal write whose address, with its low 3 bits ignored, matches a normal slot that is not yet on the bus merges into that slot. Its strobed bytes overwrite that slot's bytes, and the slot's strobe becomes the OR of both strobes. Merging needs no free slot and produces one bus write.
- R4: Device writes never merge. Each device write appears on the bus as its own transfer.
- R5: Buffered writes reach the bus in arrival order. At most one bus write is outstanding. `bus_addr` is 8-byte aligned. While `bus_valid` is high without `bus_ack`, `bus_addr`, `bus_data` and `bus_strb` hold stable. A slot is freed only by `bus_ack`.
- R6: A strongly ordered write (`wr_mtype` of 2 or 3) is issued only once the buffer is empty. It is then issued directly from the core inputs. It is accepted in the same cycle as its `bus_ack`, so on an empty buffer with an ack latency of L cycles it waits exactly L+1 cycles.
- R7: A memory barrier (`bar_kind`=0) pulse raises `mem_hold` and keeps `core_stall` low. While the barrier is active, writes are refused. `bar_done` pulses only after every earlier write has been acknowledged, and `mem_hold` drops in the next cycle.
- R8: A synchronization barrier (`bar_kind`=1) pulse raises `core_stall` and keeps `mem_hold` low until every earlier write has been acknowledged. Only then does `bar_done` pulse.
- R9: A barrier requested while the buffer is empty and the bus is idle gives `bar_done` in the cycle after the request.
- R10: `buf_idle` is high exactly when no write is buffered, outstanding on the bus or in a direct strongly ordered transfer.
- R11: Synchronous active-high `rst` empties all slots, cancels any barrier and deasserts `bus_valid`, `mem_hold`, `core_stall` and `bar_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Core write request valid |
| wr_ready | output | 1 | Core write accepted this cycle |
| wr_addr | input | ADDR_W | Core write byte address |
| wr_data | input | DATA_W | Core write data |
| wr_strb | input | DATA_W/8 | Byte strobes |
| wr_mtype | input | 2 | Memory type: 0 normal, 1 device, 2 or 3 strongly ordered |
| bar_req | input | 1 | One-cycle barrier request; ignored while a barrier is active |
| bar_kind | input | 1 | 0 memory barrier, 1 synchronization barrier |
| bar_done | output | 1 | Barrier completion pulse |
| mem_hold | output | 1 | Memory accesses held by a memory barrier |
| core_stall | output | 1 | Whole core held by a synchronization barrier |
| buf_idle | output | 1 | Buffer empty and bus idle |
| bus_valid | output | 1 | Bus write request |
| bus_ack | input | 1 | Bus write completion |
| bus_addr | output | ADDR_W | Aligned bus write address |
| bus_data | output | DATA_W | Bus write data |
| bus_strb | output | DATA_W/8 | Bus byte strobes |

## Verification
The hardest case to reach is a merge. The buffer puts its oldest slot on the bus one cycle after it arrives, and an issued slot can no longer combine. A merge therefore needs a younger slot that is still waiting. The bench's bus responder can withhold acknowledges. It parks a dummy write on the bus and then sends two writes to the same line behind it. It sweeps 64 pairs of strobe patterns, plus a full-buffer variant in which the merging write must still be accepted. Ack latency is swept as well, to time the strongly ordered handshake and the barrier completion against the last acknowledge.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    MT_NORMAL = 2'd0,
    MT_DEVICE = 2'd1,
    MT_STRONG = 2'd2
  } mtype_e;

  typedef enum logic {
    BAR_MEM  = 1'b0,
    BAR_SYNC = 1'b1
  } bar_kind_e;
endpackage

// File: rtl/wbuf_slots.sv
module wbuf_slots #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 29,
  parameter int DATA_W = 64,
  localparam int NB    = DATA_W / 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              merge,
  input  logic              pop,
  input  logic              head_issued,
  input  logic [LINE_W-1:0] in_line,
  input  logic [DATA_W-1:0] in_data,
  input  logic [NB-1:0]     in_strb,
  input  logic              in_normal,
  output logic              hit,
  output logic [CNT_W-1:0]  cnt,
  output logic [LINE_W-1:0] head_line,
  output logic [DATA_W-1:0] head_data,
  output logic [NB-1:0]     head_strb
);
  logic [DEPTH-1:0]  vld, nrm, match;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [NB-1:0]     strb_q [DEPTH];
  logic [PTR_W-1:0]  head, tail, hit_idx;
  logic [DATA_W-1:0] mrg_data;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign match[i] = vld[i] && nrm[i] && (line_q[i] == in_line) &&
                      !(head_issued && (head == PTR_W'(i)));
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (match[i]) hit_idx = PTR_W'(i);
  end

  assign hit = in_normal && (|match);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign mrg_data[b*8 +: 8] = in_strb[b] ? in_data[b*8 +: 8]
                                           : data_q[hit_idx][b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (pop) begin
        vld[head] <= 1'b0;
        head      <= step(head);
      end
      if (push) begin
        vld[tail]    <= 1'b1;
        nrm[tail]    <= in_normal;
        line_q[tail] <= in_line;
        data_q[tail] <= in_data;
        strb_q[tail] <= in_strb;
        tail         <= step(tail);
      end
      if (merge) begin
        data_q[hit_idx] <= mrg_data;
        strb_q[hit_idx] <= strb_q[hit_idx] | in_strb;
      end
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_line = line_q[head];
  assign head_data = data_q[head];
  assign head_strb = strb_q[head];
endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain #(
  parameter int LINE_W = 29,
  parameter int DATA_W = 64,
  localparam int NB    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              have_entry,
  input  logic              strong_req,
  input  logic              bar_block,
  input  logic              bus_ack,
  input  logic [LINE_W-1:0] head_line,
  input  logic [DATA_W-1:0] head_data,
  input  logic [NB-1:0]     head_strb,
  input  logic [LINE_W-1:0] core_line,
  input  logic [DATA_W-1:0] core_data,
  input  logic [NB-1:0]     core_strb,
  output logic              busy,
  output logic              so_phase,
  output logic              pop,
  output logic              so_done,
  output logic              bus_valid,
  output logic [LINE_W-1:0] bus_line,
  output logic [DATA_W-1:0] bus_data,
  output logic [NB-1:0]     bus_strb
);
  logic so_go;

  assign so_go = strong_req && !bar_block && !have_entry && !busy && !so_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      so_phase <= 1'b0;
    end else begin
      if (busy && bus_ack)                         busy <= 1'b0;
      else if (!busy && !so_phase && have_entry)   busy <= 1'b1;
      if (so_phase && bus_ack)                     so_phase <= 1'b0;
      else if (so_go)                              so_phase <= 1'b1;
    end
  end

  assign pop       = busy && bus_ack;
  assign so_done   = so_phase && bus_ack;
  assign bus_valid = busy || so_phase;
  assign bus_line  = so_phase ? core_line : head_line;
  assign bus_data  = so_phase ? core_data : head_data;
  assign bus_strb  = so_phase ? core_strb : head_strb;
endmodule

// File: rtl/wbuf_barrier.sv
module wbuf_barrier
  import wbuf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bar_req,
  input  logic bar_kind,
  input  logic drained,
  output logic active,
  output logic bar_done,
  output logic mem_hold,
  output logic core_stall
);
  bar_kind_e kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      kind_q <= BAR_MEM;
    end else if (active && drained) begin
      active <= 1'b0;
    end else if (!active && bar_req) begin
      active <= 1'b1;
      kind_q <= bar_kind_e'(bar_kind);
    end
  end

  assign bar_done   = active && drained;
  assign mem_hold   = active && (kind_q == BAR_MEM);
  assign core_stall = active && (kind_q == BAR_SYNC);
endmodule

// File: rtl/post_wbuf.sv
module post_wbuf
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  localparam int NB     = DATA_W / 8,
  localparam int OFF_W  = $clog2(NB),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NB-1:0]     wr_strb,
  input  logic [1:0]        wr_mtype,
  input  logic              bar_req,
  input  logic              bar_kind,
  output logic              bar_done,
  output logic              mem_hold,
  output logic              core_stall,
  output logic              buf_idle,
  output logic              bus_valid,
  input  logic              bus_ack,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic [NB-1:0]     bus_strb
);
  logic              is_normal, is_strong, hit, busy, so_phase, pop, so_done;
  logic              push, merge, bar_active, drained;
  logic [CNT_W-1:0]  cnt;
  logic [LINE_W-1:0] in_line, head_line, bus_line;
  logic [DATA_W-1:0] head_data;
  logic [NB-1:0]     head_strb;

  assign in_line   = wr_addr[ADDR_W-1:OFF_W];
  assign is_normal = (wr_mtype == MT_NORMAL);
  assign is_strong = (wr_mtype != MT_NORMAL) && (wr_mtype != MT_DEVICE);

  assign wr_ready = !bar_active &&
                    (is_strong ? so_done : (hit || (cnt < CNT_W'(DEPTH))));
  assign push     = wr_valid && wr_ready && !is_strong && !hit;
  assign merge    = wr_valid && wr_ready && hit;
  assign drained  = (cnt == '0) && !busy && !so_phase;
  assign buf_idle = drained;
  assign bus_addr = {bus_line, {OFF_W{1'b0}}};

  wbuf_slots #(.DEPTH(DEPTH), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_slots (
    .clk(clk), .rst(rst), .push(push), .merge(merge), .pop(pop),
    .head_issued(busy), .in_line(in_line), .in_data(wr_data),
    .in_strb(wr_strb), .in_normal(is_normal), .hit(hit), .cnt(cnt),
    .head_line(head_line), .head_data(head_data), .head_strb(head_strb)
  );

  wbuf_drain #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_drain (
    .clk(clk), .rst(rst), .have_entry(cnt != '0),
    .strong_req(wr_valid && is_strong), .bar_block(bar_active),
    .bus_ack(bus_ack), .head_line(head_line), .head_data(head_data),
    .head_strb(head_strb), .core_line(in_line), .core_data(wr_data),
    .core_strb(wr_strb), .busy(busy), .so_phase(so_phase), .pop(pop),
    .so_done(so_done), .bus_valid(bus_valid), .bus_line(bus_line),
    .bus_data(bus_data), .bus_strb(bus_strb)
  );

  wbuf_barrier u_bar (
    .clk(clk), .rst(rst), .bar_req(bar_req), .bar_kind(bar_kind),
    .drained(drained), .active(bar_active), .bar_done(bar_done),
    .mem_hold(mem_hold), .core_stall(core_stall)
  );
endmodule

// File: rtl/post_wbuf_chk.sv
module post_wbuf_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4,
  localparam int NB    = DATA_W / 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [1:0]        wr_mtype,
  input logic              bar_done,
  input logic              mem_hold,
  input logic              core_stall,
  input logic              buf_idle,
  input logic              bus_valid,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic [NB-1:0]     bus_strb,
  input logic              busy,
  input logic              so_phase,
  input logic [CNT_W-1:0]  cnt
);
  // R2
  slot_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  // R5
  single_issue_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && so_phase));

  // R5
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) &&
                                 $stable(bus_data) && $stable(bus_strb)));

  // R6
  strong_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && wr_mtype[1]) |-> (bus_valid && bus_ack));

  // R7
  hold_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_hold || core_stall) |-> !wr_ready);

  // R8
  hold_kind_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_hold && core_stall));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    bar_done |-> (buf_idle && (mem_hold || core_stall)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    buf_idle |-> !bus_valid);
endmodule

bind post_wbuf post_wbuf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_mtype(wr_mtype), .bar_done(bar_done), .mem_hold(mem_hold),
  .core_stall(core_stall), .buf_idle(buf_idle), .bus_valid(bus_valid),
  .bus_ack(bus_ack), .bus_addr(bus_addr), .bus_data(bus_data),
  .bus_strb(bus_strb), .busy(busy), .so_phase(so_phase), .cnt(cnt)
);

// File: tb/post_wbuf_bench.sv
module post_wbuf_bench;
  localparam int AW = 32, DW = 64, NB = 8, DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic          wr_valid = 1'b0, wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] wr_strb = '0;
  logic [1:0]    wr_mtype = 2'd0;
  logic          bar_req = 1'b0, bar_kind = 1'b0;
  logic          bar_done, mem_hold, core_stall, buf_idle, bus_valid;
  logic          bus_ack;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic [NB-1:0] bus_strb;

  post_wbuf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_post_wbuf (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .wr_mtype(wr_mtype), .bar_req(bar_req), .bar_kind(bar_kind),
    .bar_done(bar_done), .mem_hold(mem_hold), .core_stall(core_stall),
    .buf_idle(buf_idle), .bus_valid(bus_valid), .bus_ack(bus_ack),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_strb(bus_strb)
  );

  int n_chk = 0, n_fail = 0;
  bit ack_en = 1'b0;
  int lat = 0, wcnt = 0, log_n = 0;
  logic [AW-1:0] log_a [64];
  logic [DW-1:0] log_d [64];
  logic [NB-1:0] log_s [64];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // bus responder: acks after lat waiting cycles, logs each completed write
  initial begin
    bus_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (rst) begin
        bus_ack = 1'b0; wcnt = 0;
      end else if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (bus_valid && ack_en) begin
        if (wcnt >= lat) begin
          if (log_n < 64) begin
            log_a[log_n] = bus_addr; log_d[log_n] = bus_data; log_s[log_n] = bus_strb;
          end
          log_n++;
          bus_ack = 1'b1;
          wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [NB-1:0] s, input logic [1:0] mt,
                      output int waited, output bit ack_seen);
    waited = 0; ack_seen = 1'b0;
    @(negedge clk); #2;
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_strb = s; wr_mtype = mt;
    forever begin
      #1;
      if (wr_ready) begin
        ack_seen = bus_ack;
        @(posedge clk); #1;
        wr_valid = 1'b0;
        break;
      end
      @(negedge clk); #2;
      waited++;
      if (waited > 60) begin
        wr_valid = 1'b0;
        break;
      end
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #3;
      if (buf_idle && !bus_valid) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_bar(input bit k);
    @(negedge clk); #2;
    bar_req = 1'b1; bar_kind = k;
    @(posedge clk); #1;
    bar_req = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int t, input int i);
    return {32'(t) ^ 32'h5A5A0000, 32'(i) * 32'h01010101 + 32'h00C0FFEE};
  endfunction

  initial begin
    int w; bit ak;
    logic [NB-1:0] sp [8];
    sp[0] = 8'h01; sp[1] = 8'h03; sp[2] = 8'h0F; sp[3] = 8'hF0;
    sp[4] = 8'h80; sp[5] = 8'hAA; sp[6] = 8'h55; sp[7] = 8'hFF;

    // reset state (R11, R10)
    repeat (3) @(negedge clk);
    #3;
    check(bus_valid == 0, "R11", "bus_valid in reset", 64'(bus_valid), 0);
    check(mem_hold == 0 && core_stall == 0, "R11", "hold/stall in reset",
          64'({mem_hold, core_stall}), 0);
    check(bar_done == 0, "R11", "bar_done in reset", 64'(bar_done), 0);
    @(negedge clk); #2; rst = 1'b0;
    @(negedge clk); #3;
    check(buf_idle == 1, "R10", "idle after reset", 64'(buf_idle), 1);

    // order / fill sweep (R1, R2, R4, R5, R10)
    for (int l = 0; l < 4; l++) begin
      for (int n = 1; n <= DEPTH; n++) begin
        for (int ty = 0; ty < 2; ty++) begin
          int tot;
          int t = l * 100 + n * 10 + ty;
          ack_en = 0; lat = l; log_n = 0;
          for (int i = 0; i < n; i++) begin
            push(32'h1000 + 32'(t) * 32'h100 + 32'(i) * 8, pat(t, i), 8'hFF, 2'(ty), w, ak);
            check(w == 0, "R1", "accept without wait", 64'(w), 0);
          end
          @(negedge clk); #3;
          check(buf_idle == 0, "R10", "idle with pending writes", 64'(buf_idle), 0);
          tot = n;
          if (n == DEPTH) begin
            fork
              push(32'h1000 + 32'(t) * 32'h100 + 32'(n) * 8, pat(t, n), 8'hFF, 2'(ty), w, ak);
              begin repeat (3) @(negedge clk); ack_en = 1; end
            join
            check(w >= 3, "R2", "full buffer stalls core", 64'(w), 3);
            tot = n + 1;
          end
          ack_en = 1;
          wait_idle();
          check(log_n == tot, "R5", "bus write count", 64'(log_n), 64'(tot));
          for (int i = 0; i < tot; i++) begin
            check(log_a[i] == 32'h1000 + 32'(t) * 32'h100 + 32'(i) * 8 && log_d[i] == pat(t, i)
                  && log_s[i] == 8'hFF, "R5", "arrival order", 64'(log_a[i]),
                  64'(32'h1000 + 32'(t) * 32'h100 + 32'(i) * 8));
          end
          check(buf_idle == 1, "R10", "idle after drain", 64'(buf_idle), 1);
        end
      end
    end

    // merge sweep over strobe pairs (R3)
    lat = 0;
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        logic [DW-1:0] d1, d2, ed, msk;
        for (int k = 0; k < NB; k++) begin
          d1[k*8 +: 8] = 8'(8'h10 + k + a);
          d2[k*8 +: 8] = 8'(8'hA0 + k + b);
          ed[k*8 +: 8] = sp[b][k] ? d2[k*8 +: 8] : d1[k*8 +: 8];
          msk[k*8 +: 8] = (sp[a][k] || sp[b][k]) ? 8'hFF : 8'h00;
        end
        ack_en = 0; log_n = 0;
        push(32'h2000, 64'h1, 8'hFF, 2'd0, w, ak);
        push(32'h2108 + 32'(a), d1, sp[a], 2'd0, w, ak);
        push(32'h2108 + 32'(b), d2, sp[b], 2'd0, w, ak);
        check(w == 0, "R3", "merging write accepted", 64'(w), 0);
        ack_en = 1;
        wait_idle();
        check(log_n == 2, "R3", "merged into one write", 64'(log_n), 2);
        check(log_s[1] == (sp[a] | sp[b]) && log_a[1] == 32'h2108, "R3", "merged strobes",
              64'(log_s[1]), 64'(sp[a] | sp[b]));
        check((log_d[1] & msk) == (ed & msk), "R3", "merged bytes", log_d[1] & msk, ed & msk);
      end
    end

    // merge into a full buffer (R3)
    ack_en = 0; log_n = 0;
    push(32'h3000, 64'h0, 8'hFF, 2'd0, w, ak);
    push(32'h3008, 64'h11, 8'h01, 2'd0, w, ak);
    push(32'h3010, 64'h0, 8'hFF, 2'd0, w, ak);
    push(32'h3018, 64'h0, 8'hFF, 2'd0, w, ak);
    push(32'h3008, 64'h2200, 8'h02, 2'd0, w, ak);
    check(w == 0, "R3", "merge needs no free slot", 64'(w), 0);
    ack_en = 1; wait_idle();
    check(log_n == 4 && log_s[1] == 8'h03 && log_d[1][15:0] == 16'h2211, "R3",
          "full-buffer merge result", 64'(log_d[1][15:0]), 64'h2211);

    // device writes never merge (R4)
    ack_en = 0; log_n = 0;
    push(32'h4000, 64'h0, 8'hFF, 2'd0, w, ak);
    push(32'h4008, 64'h0A, 8'h0F, 2'd1, w, ak);
    push(32'h4008, 64'h0B, 8'hF0, 2'd1, w, ak);
    ack_en = 1; wait_idle();
    check(log_n == 3, "R4", "device writes separate", 64'(log_n), 3);
    check(log_s[1] == 8'h0F && log_s[2] == 8'hF0, "R4", "device strobes kept",
          64'({log_s[1], log_s[2]}), 64'h0FF0);

    // issued slot is not merged (R3)
    ack_en = 0; log_n = 0;
    push(32'h5000, 64'h1, 8'h01, 2'd0, w, ak);
    repeat (2) @(negedge clk);
    push(32'h5000, 64'h200, 8'h02, 2'd0, w, ak);
    ack_en = 1; wait_idle();
    check(log_n == 2, "R3", "no merge into issued slot", 64'(log_n), 2);

    // strongly ordered on empty buffer, latency sweep (R6)
    for (int l = 0; l < 4; l++) begin
      lat = l; ack_en = 1; log_n = 0;
      push(32'h6000 + 32'(l) * 8, 64'hDEAD, 8'h0F, 2'(2 + (l % 2)), w, ak);
      check(w == l + 1, "R6", "direct write wait", 64'(w), 64'(l + 1));
      check(ak == 1, "R6", "accept with ack", 64'(ak), 1);
      wait_idle();
      check(log_n == 1 && log_a[0] == 32'h6000 + 32'(l) * 8, "R6", "direct write issued",
            64'(log_n), 1);
    end

    // strongly ordered behind buffered writes (R6)
    lat = 1; ack_en = 0; log_n = 0;
    push(32'h7000, 64'h1, 8'hFF, 2'd0, w, ak);
    push(32'h7008, 64'h2, 8'hFF, 2'd1, w, ak);
    fork
      push(32'h7100, 64'h3, 8'hFF, 2'd2, w, ak);
      begin repeat (4) @(negedge clk); ack_en = 1; end
    join
    wait_idle();
    check(w >= 4 && ak == 1, "R6", "strong write waits for drain", 64'(w), 4);
    check(log_n == 3 && log_a[2] == 32'h7100 && log_a[0] == 32'h7000, "R6",
          "strong write last", 64'(log_a[2]), 64'h7100);

    // barriers with pending writes (R7, R8)
    for (int k = 0; k < 2; k++) begin
      for (int l = 0; l < 3; l++) begin
        int bad = 0;
        string rq = (k == 0) ? "R7" : "R8";
        lat = l; ack_en = 0; log_n = 0;
        for (int i = 0; i < 3; i++) push(32'h8000 + 32'(i) * 8, pat(k, i), 8'hFF, 2'(i % 2), w, ak);
        pulse_bar(k[0]);
        wr_valid = 1'b1; wr_addr = 32'h8800; wr_mtype = 2'd0; wr_strb = 8'hFF;
        for (int c = 0; c < 3; c++) begin
          @(negedge clk); #3;
          check(mem_hold == (k == 0) && core_stall == (k == 1) && !bar_done && !wr_ready, rq,
                "barrier holds", 64'({mem_hold, core_stall, bar_done, wr_ready}),
                64'({k == 0, k == 1, 2'b00}));
        end
        ack_en = 1;
        for (int c = 0; c < 100; c++) begin
          @(negedge clk); #3;
          if (bar_done) break;
          if (!(mem_hold == (k == 0) && core_stall == (k == 1))) bad++;
        end
        check(bar_done == 1 && log_n == 3, rq, "done after all acks", 64'(log_n), 3);
        check(bad == 0 && wr_ready == 0, rq, "hold kept until done", 64'(bad), 0);
        @(posedge clk); #1; wr_valid = 1'b0;
        @(negedge clk); #3;
        check(!mem_hold && !core_stall && !bar_done, rq, "hold released",
              64'({mem_hold, core_stall, bar_done}), 0);
        wait_idle();
      end
    end

    // barrier on empty buffer (R9)
    for (int k = 0; k < 2; k++) begin
      pulse_bar(k[0]);
      @(negedge clk); #3;
      check(bar_done == 1, "R9", "done next cycle", 64'(bar_done), 1);
      @(negedge clk); #3;
      check(!bar_done && !mem_hold && !core_stall, "R9", "single cycle",
            64'({bar_done, mem_hold, core_stall}), 0);
    end

    // reset mid-activity (R11)
    lat = 0; ack_en = 0; log_n = 0;
    push(32'h9000, 64'h1, 8'hFF, 2'd0, w, ak);
    push(32'h9008, 64'h2, 8'hFF, 2'd0, w, ak);
    pulse_bar(1'b1);
    @(negedge clk); #2; rst = 1'b1;
    repeat (2) @(negedge clk);
    #2; rst = 1'b0;
    @(negedge clk); #3;
    check(buf_idle && !bus_valid && !mem_hold && !core_stall && !bar_done, "R11",
          "reset clears activity", 64'({buf_idle, bus_valid, mem_hold, core_stall, bar_done}),
          64'h10);
    ack_en = 1;
    repeat (6) @(negedge clk);
    check(log_n == 0, "R11", "slots emptied by reset", 64'(log_n), 0);

    report();
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end
endmodule